// File: doc/BRIEF.md
# Health-Test Alert Threshold Checker

This block sits behind a bank of statistical entropy health tests. Each test delivers a one-cycle failure pulse on its own lane. While the block is enabled, it keeps two kinds of tally:

- a shared failure count, which feeds an alert decision;
- one running total per test lane, which software reads.

The alert trigger level comes from a single configuration word. That word carries the threshold in its low half and the bitwise inverse of the threshold in its high half. The block checks the pair on every cycle. If the halves disagree, it flags a configuration error and withholds the alert.

Once the shared count reaches a nonzero threshold, the alert rises and stays high. One clear strobe returns the alert, the shared count and all running totals to zero. Every counter saturates rather than wrapping, so a long burst of failures can never roll a tally back to a small value.

Top module: `ht_alert_thresh`

## Requirements
- R1: After reset, the shared count, the alert, the configuration-error flag and all running totals are zero. The stored threshold is 2 and its stored inverse is 0xFFFD, so two failures raise the alert.
- R2: The configuration word holds the threshold in bits 15:0 and its complement in bits 31:16. A write with `cfg_we_i` is stored at the clock edge and takes effect from the next cycle.
- R3: When bits 31:16 are not the exact bitwise complement of bits 15:0, `cfg_err_o` is high and the alert cannot rise. Failures are still counted. Once a matching word is written, the alert rises one cycle later if the count already meets the threshold.
- R4: A stored threshold of zero keeps the alert low whatever the count.
- R5: Each enabled cycle adds the number of set bits of `fail_i` to `fail_cnt_o`. The alert is raised at the same clock edge at which `fail_cnt_o` becomes greater than or equal to the threshold.
- R6: Once raised, `alert_o` stays high until `clear_i` is applied.
- R7: Bit i of `fail_i` increments only the total at `totals_o[i*32 +: 32]`. The lanes, in index order 0 to 8, are:
  - 0: repetition count
  - 1: repetition symbol
  - 2: adaptive-proportion high
  - 3: adaptive-proportion low
  - 4: bucket
  - 5: Markov high
  - 6: Markov low
  - 7: external high
  - 8: external low
- R8: While `enable_i` is low, failure pulses change neither the count nor any total.
- R9: `clear_i` zeroes the count, the alert and all totals at the next edge. It takes priority over failures that arrive in the same cycle.
- R10: A running total stops at its all-ones value instead of wrapping.
- R11: The shared failure count stops at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Counting enable (normal operation) |
| fail_i | input | NUM_TESTS (9) | Per-test failure pulses |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 2*THR_W (32) | Configuration word: threshold low, complement high |
| clear_i | input | 1 | Clears count, alert and totals |
| alert_o | output | 1 | Sticky threshold alert |
| cfg_err_o | output | 1 | Threshold and complement disagree |
| fail_cnt_o | output | THR_W (16) | Shared saturating failure count |
| totals_o | output | NUM_TESTS*TOT_W (288) | Per-test running totals, lane i at [i*TOT_W +: TOT_W] |

## Verification
The corners hardest to reach from the ports are the two saturation points. At 32 bits a running total would need billions of pulses to fill. The bench therefore adds a second instance with 6-bit totals and a 4-bit count, drives all lanes and then a single lane long enough to pin both tallies at all-ones. The other delicate case is an alert that was held back by a bad configuration word. The bench accumulates failures under a mismatched word, then writes a matching one, and checks that the alert rises exactly one cycle after the error flag drops.

// File: rtl/ht_alert_pkg.sv
`timescale 1ns/1ps
package ht_alert_pkg;
   // Lane order of the per-test failure inputs and totals.
   typedef enum int unsigned {
      HT_REPCNT    = 0,
      HT_REPSYM    = 1,
      HT_ADAPT_HI  = 2,
      HT_ADAPT_LO  = 3,
      HT_BUCKET    = 4,
      HT_MARKOV_HI = 5,
      HT_MARKOV_LO = 6,
      HT_EXT_HI    = 7,
      HT_EXT_LO    = 8,
      HT_LANES     = 9
   } ht_lane_e;

   localparam int unsigned HT_NUM_TESTS = HT_LANES;
endpackage

// File: rtl/ht_sat_ctr.sv
`timescale 1ns/1ps
module ht_sat_ctr #(
   parameter int unsigned W = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] q_o
);
   localparam logic [W-1:0] MaxVal = '1;

   logic [W-1:0] q_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      q_q <= '0;
      else if (clr_i)                   q_q <= '0;
      else if (inc_i && q_q != MaxVal)  q_q <= q_q + W'(1);
   end

   assign q_o = q_q;
endmodule

// File: rtl/ht_thresh_reg.sv
`timescale 1ns/1ps
module ht_thresh_reg #(
   parameter int unsigned THR_W   = 16,
   parameter int unsigned RST_THR = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               we_i,
   input  logic [2*THR_W-1:0] wdata_i,
   output logic [THR_W-1:0]   thr_o,
   output logic               valid_o
);
   localparam logic [THR_W-1:0] RstThr = THR_W'(RST_THR);

   logic [THR_W-1:0] thr_q, inv_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         thr_q <= RstThr;
         inv_q <= ~RstThr;
      end else if (we_i) begin
         thr_q <= wdata_i[THR_W-1:0];
         inv_q <= wdata_i[2*THR_W-1:THR_W];
      end
   end

   assign thr_o   = thr_q;
   assign valid_o = (inv_q == ~thr_q);
endmodule

// File: rtl/ht_alert_acc.sv
`timescale 1ns/1ps
module ht_alert_acc #(
   parameter int unsigned N     = 9,
   parameter int unsigned THR_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic [N-1:0]     ev_i,
   input  logic [THR_W-1:0] thr_i,
   input  logic             valid_i,
   output logic [THR_W-1:0] cnt_o,
   output logic             alert_o
);
   localparam int unsigned EV_W = $clog2(N + 1);
   localparam int unsigned PAD  = THR_W + 1 - EV_W;

   logic [EV_W-1:0]  pop;
   logic [THR_W:0]   sum;
   logic [THR_W-1:0] cnt_q, cnt_nxt;
   logic             alert_q, hit;

   always_comb begin
      pop = '0;
      for (int i = 0; i < int'(N); i++) pop = pop + EV_W'(ev_i[i]);
   end

   assign sum     = {1'b0, cnt_q} + {{PAD{1'b0}}, pop};
   assign cnt_nxt = sum[THR_W] ? '1 : sum[THR_W-1:0];
   assign hit     = valid_i && (thr_i != '0) && (cnt_nxt >= thr_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         alert_q <= 1'b0;
      end else if (clr_i) begin
         cnt_q   <= '0;
         alert_q <= 1'b0;
      end else begin
         cnt_q   <= cnt_nxt;
         alert_q <= alert_q | hit;
      end
   end

   assign cnt_o   = cnt_q;
   assign alert_o = alert_q;
endmodule

// File: rtl/ht_alert_thresh.sv
`timescale 1ns/1ps
module ht_alert_thresh #(
   parameter int unsigned NUM_TESTS = ht_alert_pkg::HT_NUM_TESTS,
   parameter int unsigned THR_W     = 16,
   parameter int unsigned TOT_W     = 32,
   parameter int unsigned RST_THR   = 2
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       enable_i,
   input  logic [NUM_TESTS-1:0]       fail_i,
   input  logic                       cfg_we_i,
   input  logic [2*THR_W-1:0]         cfg_wdata_i,
   input  logic                       clear_i,
   output logic                       alert_o,
   output logic                       cfg_err_o,
   output logic [THR_W-1:0]           fail_cnt_o,
   output logic [NUM_TESTS*TOT_W-1:0] totals_o
);
   localparam int unsigned EV_W = $clog2(NUM_TESTS + 1);

   // Elaboration-time parameter checks
   if (NUM_TESTS < 1) begin : g_bad_num
      $error("ht_alert_thresh: NUM_TESTS must be at least 1");
   end
   if (THR_W < 2 || THR_W < EV_W) begin : g_bad_thr
      $error("ht_alert_thresh: THR_W too narrow for the per-cycle event count");
   end
   if (TOT_W < 2) begin : g_bad_tot
      $error("ht_alert_thresh: TOT_W must be at least 2");
   end
   if (RST_THR >= (1 << THR_W)) begin : g_bad_rst
      $error("ht_alert_thresh: RST_THR does not fit in THR_W");
   end

   logic [NUM_TESTS-1:0] ev;
   logic [THR_W-1:0]     thr_q;
   logic                 thr_ok;

   assign ev = enable_i ? fail_i : '0;

   ht_thresh_reg #(.THR_W(THR_W), .RST_THR(RST_THR)) u_thr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (cfg_we_i),
      .wdata_i (cfg_wdata_i),
      .thr_o   (thr_q),
      .valid_o (thr_ok)
   );

   ht_alert_acc #(.N(NUM_TESTS), .THR_W(THR_W)) u_acc (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clear_i),
      .ev_i    (ev),
      .thr_i   (thr_q),
      .valid_i (thr_ok),
      .cnt_o   (fail_cnt_o),
      .alert_o (alert_o)
   );

   for (genvar g = 0; g < int'(NUM_TESTS); g++) begin : g_tot
      ht_sat_ctr #(.W(TOT_W)) u_tot (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .clr_i  (clear_i),
         .inc_i  (ev[g]),
         .q_o    (totals_o[g*TOT_W +: TOT_W])
      );
   end

   assign cfg_err_o = ~thr_ok;
endmodule

// File: rtl/ht_alert_thresh_chk.sv
`timescale 1ns/1ps
module ht_alert_thresh_chk #(
   parameter int unsigned NUM_TESTS = 9,
   parameter int unsigned THR_W     = 16,
   parameter int unsigned TOT_W     = 32
) (
   input logic                       clk_i,
   input logic                       rst_ni,
   input logic                       enable_i,
   input logic                       clear_i,
   input logic                       alert_o,
   input logic                       cfg_err_o,
   input logic [THR_W-1:0]           fail_cnt_o,
   input logic [NUM_TESTS*TOT_W-1:0] totals_o,
   input logic [THR_W-1:0]           thr_i
);
   AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (fail_cnt_o == '0 && !alert_o && totals_o == '0)); // R9

   AST_ALERT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alert_o && !clear_i) |=> alert_o); // R6

   AST_NO_ALERT_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(alert_o) |-> !$past(cfg_err_o)); // R3

   AST_ZERO_THR_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (thr_i == '0 && !alert_o) |=> !alert_o); // R4

   AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!enable_i && !clear_i) |=> ($stable(fail_cnt_o) && $stable(totals_o))); // R8

   AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clear_i |=> (fail_cnt_o >= $past(fail_cnt_o))); // R11
endmodule

bind ht_alert_thresh ht_alert_thresh_chk #(
   .NUM_TESTS(NUM_TESTS), .THR_W(THR_W), .TOT_W(TOT_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .enable_i   (enable_i),
   .clear_i    (clear_i),
   .alert_o    (alert_o),
   .cfg_err_o  (cfg_err_o),
   .fail_cnt_o (fail_cnt_o),
   .totals_o   (totals_o),
   .thr_i      (thr_q)
);

// File: tb/tb_ht_alert_thresh.sv
`timescale 1ns/1ps
module tb_ht_alert_thresh;
   localparam int N   = 9;
   localparam int TW  = 16;
   localparam int OW  = 32;
   localparam int NTW = 4;
   localparam int NOW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   // main instance
   logic            en, we, clr;
   logic [N-1:0]    fail;
   logic [2*TW-1:0] wdata;
   logic            alert, cerr;
   logic [TW-1:0]   cnt;
   logic [N*OW-1:0] tot;

   // narrow instance for saturation
   logic             n_clr;
   logic [N-1:0]     n_fail;
   logic             n_alert, n_cerr;
   logic [NTW-1:0]   n_cnt;
   logic [N*NOW-1:0] n_tot;

   int checks = 0;
   int errs   = 0;
   bit done   = 1'b0;

   ht_alert_thresh dut (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .fail_i(fail),
      .cfg_we_i(we), .cfg_wdata_i(wdata), .clear_i(clr),
      .alert_o(alert), .cfg_err_o(cerr), .fail_cnt_o(cnt), .totals_o(tot)
   );

   ht_alert_thresh #(.THR_W(NTW), .TOT_W(NOW)) dut_narrow (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(1'b1), .fail_i(n_fail),
      .cfg_we_i(1'b0), .cfg_wdata_i('0), .clear_i(n_clr),
      .alert_o(n_alert), .cfg_err_o(n_cerr), .fail_cnt_o(n_cnt), .totals_o(n_tot)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [OW-1:0] tot_of(input int i);
      return tot[i*OW +: OW];
   endfunction

   function automatic logic [NOW-1:0] ntot_of(input int i);
      return n_tot[i*NOW +: NOW];
   endfunction

   function automatic logic [2*TW-1:0] good_word(input logic [TW-1:0] t);
      return {~t, t};
   endfunction

   task automatic pulse(input logic [N-1:0] v);
      fail = v;
      @(negedge clk);
      fail = '0;
   endtask

   task automatic write_cfg(input logic [2*TW-1:0] d);
      we = 1'b1; wdata = d;
      @(negedge clk);
      we = 1'b0; wdata = '0;
   endtask

   task automatic do_clear();
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "count", 64'(cnt), 0);
      chk("R1", "alert", 64'(alert), 0);
      chk("R1", "cfg_err", 64'(cerr), 0);
      chk("R1", "totals zero", 64'(tot == '0), 1);
   endtask

   task automatic t_default_thr();
      pulse(N'(1) << ht_alert_pkg::HT_REPCNT);
      chk("R5", "count after one", 64'(cnt), 1);
      chk("R1", "alert below default", 64'(alert), 0);
      chk("R7", "repcount total", 64'(tot_of(0)), 1);
      pulse(N'(1) << ht_alert_pkg::HT_BUCKET);
      chk("R5", "count after two", 64'(cnt), 2);
      chk("R1", "alert at default 2", 64'(alert), 1);
      chk("R7", "bucket total", 64'(tot_of(4)), 1);
      chk("R7", "repsym total untouched", 64'(tot_of(1)), 0);
   endtask

   task automatic t_sticky_clear();
      @(negedge clk); @(negedge clk);
      chk("R6", "alert held idle", 64'(alert), 1);
      do_clear();
      chk("R9", "count cleared", 64'(cnt), 0);
      chk("R9", "alert cleared", 64'(alert), 0);
      chk("R9", "totals cleared", 64'(tot == '0), 1);
   endtask

   task automatic t_multi();
      write_cfg(good_word(16'd7));
      chk("R2", "matching word no error", 64'(cerr), 0);
      pulse(9'h153);
      chk("R5", "popcount 5", 64'(cnt), 5);
      chk("R5", "no alert at 5 of 7", 64'(alert), 0);
      chk("R7", "ext low total", 64'(tot_of(8)), 1);
      chk("R7", "adapt high untouched", 64'(tot_of(2)), 0);
      pulse(9'h00C);
      chk("R5", "count 7", 64'(cnt), 7);
      chk("R2", "alert at programmed 7", 64'(alert), 1);
      chk("R7", "adapt high total", 64'(tot_of(2)), 1);
      do_clear();
   endtask

   task automatic t_cfg_err();
      write_cfg({16'h1234, 16'h0001});
      chk("R3", "mismatch flagged", 64'(cerr), 1);
      pulse(9'h003);
      chk("R3", "still counts", 64'(cnt), 2);
      chk("R3", "alert withheld", 64'(alert), 0);
      write_cfg(good_word(16'd1));
      chk("R3", "error cleared", 64'(cerr), 0);
      chk("R3", "alert not yet", 64'(alert), 0);
      @(negedge clk);
      chk("R3", "alert one cycle later", 64'(alert), 1);
      do_clear();
   endtask

   task automatic t_zero_thr();
      write_cfg(good_word(16'd0));
      chk("R4", "zero threshold valid", 64'(cerr), 0);
      pulse('1);
      pulse('1);
      chk("R4", "count 18", 64'(cnt), 18);
      chk("R4", "no alert at zero", 64'(alert), 0);
      do_clear();
   endtask

   task automatic t_enable();
      write_cfg(good_word(16'd1));
      en = 1'b0;
      pulse('1);
      chk("R8", "count held", 64'(cnt), 0);
      chk("R8", "totals held", 64'(tot == '0), 1);
      chk("R8", "no alert", 64'(alert), 0);
      en = 1'b1;
      pulse(N'(1) << ht_alert_pkg::HT_EXT_HI);
      chk("R8", "counts when enabled", 64'(cnt), 1);
      chk("R7", "ext high total", 64'(tot_of(7)), 1);
      do_clear();
   endtask

   task automatic t_clear_priority();
      write_cfg(good_word(16'd100));
      pulse('1);
      chk("R9", "count before", 64'(cnt), 9);
      fail = '1; clr = 1'b1;
      @(negedge clk);
      fail = '0; clr = 1'b0;
      chk("R9", "clear beats failures count", 64'(cnt), 0);
      chk("R9", "clear beats failures totals", 64'(tot == '0), 1);
   endtask

   task automatic t_saturate();
      n_fail = '1;
      @(negedge clk);
      chk("R11", "narrow count 9", 64'(n_cnt), 9);
      @(negedge clk);
      chk("R11", "narrow count saturates", 64'(n_cnt), 15);
      @(negedge clk);
      chk("R11", "narrow count stays", 64'(n_cnt), 15);
      n_fail = 9'h001;
      for (int i = 0; i < 70; i++) @(negedge clk);
      n_fail = '0;
      chk("R10", "total saturates", 64'(ntot_of(0)), 63);
      chk("R10", "other lane", 64'(ntot_of(1)), 3);
      chk("R5", "narrow alert", 64'(n_alert), 1);
   endtask

   initial begin
      en = 1'b1; we = 1'b0; clr = 1'b0; fail = '0; wdata = '0;
      n_clr = 1'b0; n_fail = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_default_thr();
      t_sticky_clear();
      t_multi();
      t_cfg_err();
      t_zero_thr();
      t_enable();
      t_clear_priority();
      t_saturate();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
      $finish;
   end

   initial begin
      for (int c = 0; c < 200000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++; errs++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
         $finish;
      end
   end
endmodule